// File: doc/BRIEF.md
# Bidirectional 16-bit Timer Counter with Byte-Wide Register Access

This block is a 16-bit counter that steps up or down by one on each timer clock enable. A clock-select field chooses where that enable comes from: the system clock, two fixed divisions of it, or rising edges on an external pin. An outside control block supplies the step, direction and clear controls. It also supplies an event input that makes the counter act as if it had just wrapped past its limit. The counter wraps at a programmable 16-bit limit and raises a sticky overflow flag. That flag doubles as the interrupt request.

A processor with an 8-bit data path reaches both the counter and the limit register through one shared high-byte holding register. Reading a low byte captures the matching high byte in the holding register, so a 16-bit value is sampled in one cycle. Writing a high byte only fills the holding register. The following low-byte write then commits all 16 bits at once. A processor write to the counter always wins over clear, event and step actions in the same cycle.

Top module: `updn_timer16`

## Requirements
- R1: After reset the counter is 0x0000, the limit register is 0xFFFF, the holding register is 0x00 and the overflow flag is 0.
- R2: Register offsets on `cpu_addr`: 0 counter low byte, 1 holding register (counter high), 2 limit low byte, 3 holding register (limit high), 4 status with the overflow flag in bit 0. `cpu_rdata` shows the selected byte in the same cycle `cpu_rd` is high and is 0 otherwise.
- R3: A read at offset 0 (or 2) copies the counter's (or limit's) current high byte into the holding register at the end of that cycle, so a following read at offset 1 (or 3) returns the high byte that matches the low byte just read.
- R4: A write at offset 1 or 3 changes only the holding register. A write at offset 0 (or 2) loads the counter (or limit) with {holding register, write data} in a single cycle.
- R5: On a timer tick with `cnt_en` high, the counter adds one when `cnt_up` is 1 and subtracts one when `cnt_up` is 0, with carry and borrow across the byte boundary.
- R6: Counting up from a value equal to the limit gives 0 and sets the overflow flag. Counting down from 0 gives the limit value and leaves the flag unchanged.
- R7: On a timer tick, `cnt_clr` forces the counter to 0 and takes priority over `evt_trig` and `cnt_en`. Without a tick it has no effect.
- R8: On a timer tick, `evt_trig` forces the counter to 0 and sets the overflow flag, the same action as an upward wrap at the limit. Without a tick it has no effect.
- R9: A write at offset 0 overrides any clear, event or count action in the same cycle. The counter takes exactly the written value and the flag is not set by the suppressed event.
- R10: `clk_sel` chooses the timer tick: 0 none, 1 every clock, 2 one clock in 8, 3 one clock in 64, 4 one tick per rising edge of `ext_clk_pin` after a two-stage synchronizer, 5 to 7 none. With no tick the counter holds its value.
- R11: `at_top` is high exactly when the counter equals the limit, and `at_bottom` is high exactly when the counter is 0.
- R12: The overflow flag stays set until a write at offset 4 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set, and a set in the same cycle wins over a clear. `ovf_irq` shows the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while `cpu_rd` is high |
| clk_sel | input | 3 | Timer tick source select |
| ext_clk_pin | input | 1 | Asynchronous external count pin |
| cnt_en | input | 1 | Step the counter on a tick |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| cnt_clr | input | 1 | Clear the counter on a tick |
| evt_trig | input | 1 | External event requesting the wrap action |
| at_top | output | 1 | Counter equals the limit |
| at_bottom | output | 1 | Counter equals zero |
| ovf_irq | output | 1 | Overflow flag / interrupt request |

## Verification
On every cycle the assertions check the following: the held value when no tick source is selected, both wrap directions, clear on a tick, the exact value loaded by a low-byte write, the capture of the high byte on a low-byte read, and the stickiness and origin of the overflow flag. Some behaviour can only be shown by the bench's scenarios. This includes the tick rates for each divider and the external pin measured over whole windows, and the holding-register sequences across several bus accesses. It also includes the priority outcomes when a write, a clear and an event coincide, and the absence of any effect from a clear or event without a tick.

// File: rtl/updn_tmr_pkg.sv
// Shared constants and types for the bidirectional timer counter.
// Assumes an 8-bit processor data path; offsets and select codes are fixed here.
package updn_tmr_pkg;

    localparam int BYTE_W = 8;

    // Register offsets decoded on cpu_addr
    typedef enum logic [2:0] {
        ADR_CNT_LO = 3'd0,
        ADR_CNT_HI = 3'd1,
        ADR_TOP_LO = 3'd2,
        ADR_TOP_HI = 3'd3,
        ADR_STAT   = 3'd4
    } reg_adr_e;

    // Timer tick source codes on clk_sel
    typedef enum logic [2:0] {
        CS_STOP  = 3'd0,
        CS_SYS   = 3'd1,
        CS_DIV_A = 3'd2,
        CS_DIV_B = 3'd3,
        CS_EXT   = 3'd4
    } clk_sel_e;

endpackage

// File: rtl/updn_tmr_tick.sv
// Timer tick generator.
// Produces a one-cycle enable from the chosen source: every clock, two
// power-of-two divisions of a free-running prescaler, or rising edges of an
// asynchronous pin passed through a synchronizer chain.
// Assumes DIV_A and DIV_B are powers of two with 2 <= DIV_A <= DIV_B.
module updn_tmr_tick
    import updn_tmr_pkg::*;
#(
    parameter int DIV_A       = 8,
    parameter int DIV_B       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       ext_clk_pin,
    output logic       tick
);

    localparam int PW = $clog2(DIV_B);
    localparam int AW = $clog2(DIV_A);
    localparam logic [PW-1:0] P_ONE = 1;

    logic [PW-1:0]        presc_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 hit_a;
    logic                 hit_b;
    logic                 ext_edge;

    // Free-running prescaler shared by both divided sources
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + P_ONE;
    end

    // Synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_pin};
    end

    // Divider hits: low prescaler bits all ones
    generate
        if (AW == 0) begin : g_a_full
            assign hit_a = 1'b1;
        end else begin : g_a_div
            assign hit_a = &presc_q[AW-1:0];
        end
    endgenerate
    assign hit_b = &presc_q;

    // Rising edge once the pin has passed the synchronizer
    assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    // Source selection; unused codes give no tick
    always_comb begin
        case (clk_sel_e'(clk_sel))
            CS_SYS:   tick = 1'b1;
            CS_DIV_A: tick = hit_a;
            CS_DIV_B: tick = hit_b;
            CS_EXT:   tick = ext_edge;
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/updn_tmr_regs.sv
// Byte-wide register front end.
// Holds the shared high-byte holding register and the limit register,
// decodes processor accesses, and builds the 16-bit load for the counter.
// Assumes CNT_W == 2 * BYTE_W and single-cycle read/write strobes.
module updn_tmr_regs
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              ovf_q,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic [CNT_W-1:0]  top_q,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              flag_clr
);

    localparam int HI_W = CNT_W - BYTE_W;
    localparam logic [CNT_W-1:0] TOP_RST = '1;

    logic [HI_W-1:0]   temp_q;
    logic              wr_cnt_lo, wr_cnt_hi, wr_top_lo, wr_top_hi, wr_stat;
    logic              rd_cnt_lo, rd_top_lo;
    logic [BYTE_W-1:0] rd_mux;

    // Access decode
    always_comb begin
        wr_cnt_lo = cpu_wr && (cpu_addr == ADR_CNT_LO);
        wr_cnt_hi = cpu_wr && (cpu_addr == ADR_CNT_HI);
        wr_top_lo = cpu_wr && (cpu_addr == ADR_TOP_LO);
        wr_top_hi = cpu_wr && (cpu_addr == ADR_TOP_HI);
        wr_stat   = cpu_wr && (cpu_addr == ADR_STAT);
        rd_cnt_lo = cpu_rd && (cpu_addr == ADR_CNT_LO);
        rd_top_lo = cpu_rd && (cpu_addr == ADR_TOP_LO);
    end

    // Holding register: filled by high-byte writes or captured on low-byte reads
    always_ff @(posedge clk) begin
        if (!rst_n)                    temp_q <= '0;
        else if (wr_cnt_hi || wr_top_hi) temp_q <= cpu_wdata[HI_W-1:0];
        else if (rd_cnt_lo)            temp_q <= cnt_q[CNT_W-1:BYTE_W];
        else if (rd_top_lo)            temp_q <= top_q[CNT_W-1:BYTE_W];
    end

    // Limit register: all bits committed by a low-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)         top_q <= TOP_RST;
        else if (wr_top_lo) top_q <= {temp_q, cpu_wdata};
    end

    // Counter load request and flag clear request toward the core
    always_comb begin
        load     = wr_cnt_lo;
        load_val = {temp_q, cpu_wdata};
        flag_clr = wr_stat && cpu_wdata[0];
    end

    // Read data selection
    always_comb begin
        case (reg_adr_e'(cpu_addr))
            ADR_CNT_LO: rd_mux = cnt_q[BYTE_W-1:0];
            ADR_CNT_HI: rd_mux = BYTE_W'(temp_q);
            ADR_TOP_LO: rd_mux = top_q[BYTE_W-1:0];
            ADR_TOP_HI: rd_mux = BYTE_W'(temp_q);
            ADR_STAT:   rd_mux = {{(BYTE_W-1){1'b0}}, ovf_q};
            default:    rd_mux = '0;
        endcase
    end

    // Drive data only while a read is active
    assign cpu_rdata = cpu_rd ? rd_mux : '0;

endmodule

// File: rtl/updn_tmr_core.sv
// Counter core.
// Applies, in priority order, a processor load, a clear, the wrap event and
// an up/down step; tracks the sticky overflow flag and the limit compares.
// Assumes tick is a single-cycle enable in the clk domain.
module updn_tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             cnt_up,
    input  logic             cnt_clr,
    input  logic             evt_trig,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] top_q,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic             at_top,
    output logic             at_bottom
);

    localparam logic [CNT_W-1:0] ONE = 1;

    logic [CNT_W-1:0] cnt_d;
    logic             wrap_set;

    // Limit and zero compares
    always_comb begin
        at_top    = (cnt_q == top_q);
        at_bottom = (cnt_q == '0);
    end

    // Next-value selection with load > clear > event > step
    always_comb begin
        cnt_d    = cnt_q;
        wrap_set = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (tick) begin
            if (cnt_clr) begin
                cnt_d = '0;
            end else if (evt_trig) begin
                cnt_d    = '0;
                wrap_set = 1'b1;
            end else if (cnt_en) begin
                if (cnt_up) begin
                    if (at_top) begin
                        cnt_d    = '0;
                        wrap_set = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end else begin
                    cnt_d = at_bottom ? top_q : (cnt_q - ONE);
                end
            end
        end
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Sticky overflow flag; a set wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (wrap_set) ovf_q <= 1'b1;
        else if (flag_clr) ovf_q <= 1'b0;
    end

endmodule

// File: rtl/updn_timer16.sv
// Top level of the bidirectional timer counter with byte-wide access.
// Connects the tick generator, the register front end and the counter core.
// Assumes a single synchronous clock; ext_clk_pin may be asynchronous.
module updn_timer16
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_A       = 8,
    parameter int DIV_B       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cpu_addr,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic [2:0] clk_sel,
    input  logic       ext_clk_pin,
    input  logic       cnt_en,
    input  logic       cnt_up,
    input  logic       cnt_clr,
    input  logic       evt_trig,
    output logic       at_top,
    output logic       at_bottom,
    output logic       ovf_irq
);

    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_q;
    logic             ovf_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             flag_clr;

    updn_tmr_tick #(
        .DIV_A       (DIV_A),
        .DIV_B       (DIV_B),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_sel     (clk_sel),
        .ext_clk_pin (ext_clk_pin),
        .tick        (tick)
    );

    updn_tmr_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_wdata (cpu_wdata),
        .cnt_q     (cnt_q),
        .ovf_q     (ovf_q),
        .cpu_rdata (cpu_rdata),
        .top_q     (top_q),
        .load      (load),
        .load_val  (load_val),
        .flag_clr  (flag_clr)
    );

    updn_tmr_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_en    (cnt_en),
        .cnt_up    (cnt_up),
        .cnt_clr   (cnt_clr),
        .evt_trig  (evt_trig),
        .load      (load),
        .load_val  (load_val),
        .top_q     (top_q),
        .flag_clr  (flag_clr),
        .cnt_q     (cnt_q),
        .ovf_q     (ovf_q),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    // Flag drives the interrupt request directly
    assign ovf_irq = ovf_q;

endmodule

// File: rtl/updn_tmr_chk.sv
// Property checker for the timer counter, attached to the top by bind.
// Observes ports and the internal tick, counter, limit and holding registers.
module updn_tmr_chk
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic [2:0]       cpu_addr,
    input logic             cpu_wr,
    input logic             cpu_rd,
    input logic [7:0]       cpu_wdata,
    input logic             cnt_en,
    input logic             cnt_up,
    input logic             cnt_clr,
    input logic             evt_trig,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] top_q,
    input logic [7:0]       temp_q,
    input logic             ovf_q
);

    logic wr_lo;
    logic clr_wr;
    assign wr_lo  = cpu_wr && (cpu_addr == ADR_CNT_LO);
    assign clr_wr = cpu_wr && (cpu_addr == ADR_STAT) && cpu_wdata[0];

    // R10: no tick source selected and no load keeps the counter still
    p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel == 3'd0 || clk_sel > 3'd4) && !wr_lo) |=> $stable(cnt_q));

    // R6: upward step at the limit wraps to zero and raises the flag
    p_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en && cnt_up && !cnt_clr && !evt_trig && !wr_lo && cnt_q == top_q)
        |=> (cnt_q == '0) && ovf_q);

    // R6: downward step at zero reloads the limit
    p_wrap_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en && !cnt_up && !cnt_clr && !evt_trig && !wr_lo && cnt_q == '0)
        |=> cnt_q == $past(top_q));

    // R7: clear on a tick without a load gives zero
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_clr && !wr_lo) |=> cnt_q == '0);

    // R9: low-byte write commits {holding, data} regardless of other controls
    p_load_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_q == {$past(temp_q), $past(cpu_wdata)});

    // R3: low-byte read captures the counter's high byte
    p_lo_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr == ADR_CNT_LO) |=> temp_q == $past(cnt_q[CNT_W-1:8]));

    // R12: the flag stays set until a write of one to status bit 0
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_wr) |=> ovf_q);

    // R12: the flag only rises after a timer tick
    p_flag_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(tick));

endmodule

bind updn_timer16 updn_tmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wdata (cpu_wdata),
    .cnt_en    (cnt_en),
    .cnt_up    (cnt_up),
    .cnt_clr   (cnt_clr),
    .evt_trig  (evt_trig),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .top_q     (top_q),
    .temp_q    (u_regs.temp_q),
    .ovf_q     (ovf_q)
);

// File: tb/updn_timer16_tb_top.sv
// Scoreboard bench: driver tasks queue expected bytes or port flags, a
// negedge monitor pops and compares them while a read or probe is active.
module updn_timer16_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [2:0] clk_sel = '0;
    logic       ext_clk_pin = 1'b0;
    logic       cnt_en = 1'b0;
    logic       cnt_up = 1'b1;
    logic       cnt_clr = 1'b0;
    logic       evt_trig = 1'b0;
    logic       at_top, at_bottom, ovf_irq;
    logic       probe = 1'b0;

    int n_cmp  = 0;
    int n_fail = 0;

    typedef struct {
        bit         is_rd;
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    updn_timer16 dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_wr      (cpu_wr),
        .cpu_rd      (cpu_rd),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .clk_sel     (clk_sel),
        .ext_clk_pin (ext_clk_pin),
        .cnt_en      (cnt_en),
        .cnt_up      (cnt_up),
        .cnt_clr     (cnt_clr),
        .evt_trig    (evt_trig),
        .at_top      (at_top),
        .at_bottom   (at_bottom),
        .ovf_irq     (ovf_irq)
    );

    // Monitor: compare the oldest expected item when a read or probe is live
    always @(negedge clk) begin
        if (cpu_rd || probe) begin
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected observation, no queued item");
            end else begin
                sb_item_t it;
                logic [7:0] got;
                it  = sb_q.pop_front();
                got = it.is_rd ? cpu_rdata : {5'b0, at_top, at_bottom, ovf_irq};
                n_cmp++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%02h expected 0x%02h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic summary();
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items never observed", sb_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    // All driver tasks start and end at one time unit after a rising edge
    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk); #1 cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string req);
        sb_q.push_back('{1'b1, e, req});
        cpu_addr = a; cpu_rd = 1'b1;
        @(posedge clk); #1 cpu_rd = 1'b0;
    endtask

    // Expected flags as {at_top, at_bottom, ovf_irq}
    task automatic probe_ports(input logic [2:0] e, input string req);
        sb_q.push_back('{1'b0, {5'b0, e}, req});
        probe = 1'b1;
        @(posedge clk); #1 probe = 1'b0;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        bus_wr(3'd1, v[15:8]);
        bus_wr(3'd0, v[7:0]);
    endtask

    task automatic chk_cnt(input logic [15:0] e, input string req);
        bus_rd(3'd0, e[7:0], req);
        bus_rd(3'd1, e[15:8], req);
    endtask

    task automatic run_en(input int n);
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 cnt_en = 1'b0;
    endtask

    task automatic one_cycle_clr_trig(input logic c, input logic t);
        cnt_clr = c; evt_trig = t;
        @(posedge clk); #1 cnt_clr = 1'b0; evt_trig = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R11 / R2: reset state
        probe_ports(3'b010, "R1 reset flags (R11 bottom)");
        chk_cnt(16'h0000, "R1 counter reset");
        bus_rd(3'd2, 8'hFF, "R1 limit low reset");
        bus_rd(3'd3, 8'hFF, "R1 limit high reset");
        bus_rd(3'd4, 8'h00, "R2 status reset");

        // R4 / R3 / R2: atomic load and holding register behaviour
        set_cnt(16'h1234);
        chk_cnt(16'h1234, "R4 16-bit load");
        bus_wr(3'd1, 8'hAB);
        bus_rd(3'd1, 8'hAB, "R2 holding register readback");
        chk_cnt(16'h1234, "R3 high byte refreshed, R4 high write alone no load");

        // R10: stopped codes hold the value
        clk_sel = 3'd0; run_en(10);
        chk_cnt(16'h1234, "R10 code 0 holds");
        clk_sel = 3'd5; run_en(10);
        chk_cnt(16'h1234, "R10 code 5 holds");

        // R5: up and down steps every clock
        clk_sel = 3'd1; cnt_up = 1'b1; run_en(5);
        chk_cnt(16'h1239, "R5 up five");
        cnt_up = 1'b0; run_en(3);
        chk_cnt(16'h1236, "R5 down three");
        set_cnt(16'h00FF); cnt_up = 1'b1; run_en(1);
        chk_cnt(16'h0100, "R5 carry into high byte");

        // R6 / R11 / R12: wrap at a programmed limit
        bus_wr(3'd3, 8'h00); bus_wr(3'd2, 8'h05);
        bus_rd(3'd2, 8'h05, "R4 limit low");
        bus_rd(3'd3, 8'h00, "R3 limit high captured");
        set_cnt(16'h0003); run_en(2);
        probe_ports(3'b100, "R11 at limit");
        run_en(1);
        probe_ports(3'b011, "R6 up wrap to zero sets flag");
        bus_rd(3'd4, 8'h01, "R12 status flag");
        cnt_up = 1'b0; run_en(1);
        chk_cnt(16'h0005, "R6 down wrap reloads limit");
        probe_ports(3'b101, "R6 down wrap keeps flag");
        bus_wr(3'd4, 8'h00);
        probe_ports(3'b101, "R12 write zero keeps flag");
        bus_wr(3'd4, 8'h01);
        probe_ports(3'b100, "R12 write one clears flag");

        // R7: clear needs a tick and beats the event
        clk_sel = 3'd0; one_cycle_clr_trig(1'b1, 1'b0);
        chk_cnt(16'h0005, "R7 clear without tick ignored");
        clk_sel = 3'd1; set_cnt(16'h0003);
        one_cycle_clr_trig(1'b1, 1'b1);
        probe_ports(3'b010, "R7 clear beats event, no flag");
        chk_cnt(16'h0000, "R7 clear result");

        // R8: event needs a tick, then wraps and flags
        set_cnt(16'h0003); clk_sel = 3'd0;
        one_cycle_clr_trig(1'b0, 1'b1);
        chk_cnt(16'h0003, "R8 event without tick ignored");
        clk_sel = 3'd1;
        one_cycle_clr_trig(1'b0, 1'b1);
        probe_ports(3'b011, "R8 event zeroes and flags");
        bus_wr(3'd4, 8'h01);

        // R9: a counter write overrides step, clear and event in the same cycle
        bus_wr(3'd1, 8'h00);
        cnt_up = 1'b1; cnt_en = 1'b1;
        bus_wr(3'd0, 8'h02);
        cnt_en = 1'b0;
        chk_cnt(16'h0002, "R9 write beats step");
        bus_wr(3'd1, 8'h00);
        cnt_clr = 1'b1; evt_trig = 1'b1;
        bus_wr(3'd0, 8'h09);
        cnt_clr = 1'b0; evt_trig = 1'b0;
        chk_cnt(16'h0009, "R9 write beats clear and event");
        probe_ports(3'b000, "R9 suppressed event sets no flag");

        // R10: divided and external tick sources
        bus_wr(3'd3, 8'hFF); bus_wr(3'd2, 8'hFF);
        set_cnt(16'h0000); clk_sel = 3'd2; run_en(64);
        chk_cnt(16'h0008, "R10 divide by 8");
        set_cnt(16'h0000); clk_sel = 3'd3; run_en(128);
        chk_cnt(16'h0002, "R10 divide by 64");
        set_cnt(16'h0000); clk_sel = 3'd4; cnt_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ext_clk_pin = 1'b1; repeat (2) @(posedge clk); #1;
            ext_clk_pin = 1'b0; repeat (2) @(posedge clk); #1;
        end
        repeat (5) @(posedge clk); #1 cnt_en = 1'b0;
        chk_cnt(16'h0004, "R10 external rising edges");

        repeat (2) @(posedge clk);
        summary();
    end

endmodule